// File: doc/BRIEF.md
# NAND Die Bus Front End

This block is the device-side decoder that sits behind the byte-wide pins of a small NAND flash die. It watches chip select, the command and address latch strobes, the write and read strobes and the write-protect pin, all sampled on the core clock. It sorts each rising write strobe into a command, an address byte or a data byte. It keeps the column pointer that serial reads walk through, drives a ready flag, and returns to standby when the die is deselected. A single 264-byte page register stands in for the cell array. Read and program busy times are parameter counts rather than analog delays.

Four commands are decoded. 00h opens a page read. 80h opens a page load. 10h commits a loaded page as a program. 70h switches the read path to a status byte. Both the read and the load take three address bytes after the command. The first of these is the starting column. The other two carry the row and are accepted but not stored, because there is only one page. The pins are strobe driven, so no valid/ready handshake exists here. Every strobe is acted on in the clock cycle in which its edge is first seen.

Top module: `nand_bus_frontend`

## Requirements
- R1: With sel_n low, a rising edge of wr_n while cmd_latch is high captures bus_in as a command. While sel_n is high, write-strobe edges have no effect.
- R2: After command 00h, three write edges with addr_latch high are taken as address bytes. The first sets the starting column, zero-extended. The second and third are row bytes and are discarded.
- R3: In read-out, each falling edge of rd_n returns the byte at the current column on bus_out and advances the column by one. The column wraps from 263 to 0.
- R4: After 80h and its three address bytes, each write edge with both latch strobes low stores bus_in at the current column and advances the column, wrapping the same way.
- R5: Command 10h issued while loading drops ready for exactly PG_CYC cycles, then returns the block to idle.
- R6: The third read address byte drops ready for exactly RD_CYC cycles. Read-out follows.
- R7: After 70h, reads return the status byte: bit 7 equals prot_n, bit 6 is 1 when ready and 0 when busy, and bits 5..0 are 0. 70h is accepted even while busy.
- R8: bus_oe is high only while sel_n and rd_n are both low and either status is selected or read-out is active. It is low out of reset and during a busy period without status.
- R9: Raising sel_n in any state other than program busy returns the block to idle and clears status selection. A read busy period is abandoned, and ready is high in the following cycle.
- R10: Raising sel_n during program busy is ignored, and the busy period runs its full length.
- R11: While prot_n is low, 80h, data writes and 10h are all ignored. No busy period starts and the page is left unchanged.
- R12: While busy, every command other than 70h is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Die select, active low |
| cmd_latch | input | 1 | Routes the next write edge to the command register |
| addr_latch | input | 1 | Routes the next write edge to the address path |
| wr_n | input | 1 | Write strobe; acted on at its rising edge |
| rd_n | input | 1 | Read strobe; acted on at its falling edge |
| prot_n | input | 1 | Write protect, active low |
| bus_in | input | 8 | Byte arriving on the shared bus |
| bus_out | output | 8 | Byte driven toward the shared bus |
| bus_oe | output | 1 | Output enable for bus_out |
| ready | output | 1 | High when no read or program busy period is running |

## Verification
The bench walks the column pointer across the 263-to-0 wrap. A design that saturated or overran there would return a wrong byte or a byte from outside the page. It deselects the die once during a read busy period and once during a program busy period. A design that treated both cases alike would either hang busy after the abort or cut the program period short. It issues 70h in the middle of a read busy period and reads with no status selected while busy. These checks catch a design that enables the bus too early or reports a stale busy bit. Write-protect toggling between address and data catches a design that checks prot_n only when the command is issued.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RD_BUSY,
    ST_RD_OUT,
    ST_LOAD,
    ST_PG_BUSY
  } nbf_state_t;

  localparam logic [7:0] OP_READ   = 8'h00;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_LOAD   = 8'h80;
  localparam logic [7:0] OP_COMMIT = 8'h10;

  localparam int ADDR_BYTES = 3;

endpackage

// File: rtl/nbf_edge.sv
module nbf_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (!rst_n) prev[i] <= 1'b1;
      else        prev[i] <= pin[i];
    end
    assign rise[i] = pin[i] & ~prev[i];
    assign fall[i] = ~pin[i] & prev[i];
  end
endmodule

// File: rtl/nbf_page_buf.sv
module nbf_page_buf #(
  parameter int DEPTH = 264,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nbf_ctrl.sv
module nbf_ctrl
  import nbf_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int RD_CYC     = 10,
  parameter int PG_CYC     = 14,
  localparam int CW        = $clog2(PAGE_BYTES),
  localparam int MAXC      = (RD_CYC > PG_CYC) ? RD_CYC : PG_CYC,
  localparam int BW        = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          cmd_latch,
  input  logic          addr_latch,
  input  logic          prot_n,
  input  logic [7:0]    bus_in,
  input  logic          we_rise,
  input  logic          re_fall,
  input  logic [7:0]    buf_rd,
  output logic [CW-1:0] col,
  output logic          buf_we,
  output logic [7:0]    rd_byte,
  output logic          stat_sel,
  output logic          ready,
  output logic          pg_busy,
  output logic          reading,
  output logic          drive_ok
);
  nbf_state_t st;
  logic [BW-1:0] cnt;
  logic [1:0]    acnt;
  logic          is_prog;
  logic [CW-1:0] col_nx;
  logic          we_cmd, we_adr, we_dat;

  assign col_nx  = (col == CW'(PAGE_BYTES - 1)) ? '0 : col + 1'b1;
  assign we_cmd  = we_rise & cmd_latch;
  assign we_adr  = we_rise & addr_latch & ~cmd_latch;
  assign we_dat  = we_rise & ~addr_latch & ~cmd_latch;
  assign buf_we  = we_dat & ~sel_n & prot_n & (st == ST_LOAD);
  assign ready   = (st != ST_RD_BUSY) && (st != ST_PG_BUSY);
  assign pg_busy = (st == ST_PG_BUSY);
  assign reading = (st == ST_RD_OUT) && !stat_sel;
  assign drive_ok = stat_sel || (st == ST_RD_OUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      acnt     <= '0;
      is_prog  <= 1'b0;
      col      <= '0;
      rd_byte  <= '0;
      stat_sel <= 1'b0;
    end else if (st == ST_PG_BUSY) begin
      // program busy: deselect and all other commands are ignored
      if (cnt == '0) st <= ST_IDLE;
      else           cnt <= cnt - 1'b1;
      if (!sel_n && we_cmd && bus_in == OP_STATUS) stat_sel <= 1'b1;
    end else if (sel_n) begin
      st       <= ST_IDLE;
      acnt     <= '0;
      stat_sel <= 1'b0;
    end else if (st == ST_RD_BUSY) begin
      if (cnt == '0) st <= ST_RD_OUT;
      else           cnt <= cnt - 1'b1;
      if (we_cmd && bus_in == OP_STATUS) stat_sel <= 1'b1;
    end else begin
      if (we_cmd) begin
        unique case (bus_in)
          OP_READ: begin
            st       <= ST_ADDR;
            is_prog  <= 1'b0;
            acnt     <= '0;
            stat_sel <= 1'b0;
          end
          OP_LOAD: begin
            if (prot_n) begin
              st       <= ST_ADDR;
              is_prog  <= 1'b1;
              acnt     <= '0;
              stat_sel <= 1'b0;
            end
          end
          OP_COMMIT: begin
            if (st == ST_LOAD && prot_n) begin
              st       <= ST_PG_BUSY;
              cnt      <= BW'(PG_CYC - 1);
              stat_sel <= 1'b0;
            end
          end
          OP_STATUS: stat_sel <= 1'b1;
          default: ;
        endcase
      end else if (we_adr && st == ST_ADDR) begin
        if (acnt == 2'd0) col <= CW'(bus_in);
        if (acnt == 2'(ADDR_BYTES - 1)) begin
          acnt <= '0;
          if (is_prog) begin
            st <= ST_LOAD;
          end else begin
            st  <= ST_RD_BUSY;
            cnt <= BW'(RD_CYC - 1);
          end
        end else begin
          acnt <= acnt + 1'b1;
        end
      end else if (buf_we) begin
        col <= col_nx;
      end

      if (re_fall && st == ST_RD_OUT && !stat_sel) begin
        rd_byte <= buf_rd;
        col     <= col_nx;
      end
    end
  end
endmodule

// File: rtl/nand_bus_frontend.sv
module nand_bus_frontend #(
  parameter int PAGE_BYTES = 264,
  parameter int RD_CYC     = 10,
  parameter int PG_CYC     = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       cmd_latch,
  input  logic       addr_latch,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic       prot_n,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       bus_oe,
  output logic       ready
);
  localparam int CW = $clog2(PAGE_BYTES);

  logic [1:0]    rise, fall;
  logic          we_rise, re_fall;
  logic [CW-1:0] col;
  logic          buf_we, stat_sel, pg_busy, reading, drive_ok;
  logic [7:0]    buf_rd, rd_byte, status;

  nbf_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  ({rd_n, wr_n}),
    .rise (rise),
    .fall (fall)
  );
  assign we_rise = rise[0];
  assign re_fall = fall[1];

  nbf_page_buf #(.DEPTH(PAGE_BYTES), .AW(CW)) u_buf (
    .clk    (clk),
    .wr_en  (buf_we),
    .wr_addr(col),
    .wr_data(bus_in),
    .rd_addr(col),
    .rd_data(buf_rd)
  );

  nbf_ctrl #(.PAGE_BYTES(PAGE_BYTES), .RD_CYC(RD_CYC), .PG_CYC(PG_CYC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .cmd_latch (cmd_latch),
    .addr_latch(addr_latch),
    .prot_n    (prot_n),
    .bus_in    (bus_in),
    .we_rise   (we_rise),
    .re_fall   (re_fall),
    .buf_rd    (buf_rd),
    .col       (col),
    .buf_we    (buf_we),
    .rd_byte   (rd_byte),
    .stat_sel  (stat_sel),
    .ready     (ready),
    .pg_busy   (pg_busy),
    .reading   (reading),
    .drive_ok  (drive_ok)
  );

  assign status  = {prot_n, ready, 6'b0};
  assign bus_out = stat_sel ? status : rd_byte;
  assign bus_oe  = !sel_n && !rd_n && drive_ok;
endmodule

// File: rtl/nbf_checker.sv
module nbf_checker #(
  parameter int PAGE_BYTES = 264,
  parameter int PG_CYC     = 14,
  localparam int CW        = $clog2(PAGE_BYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_n,
  input logic          prot_n,
  input logic [7:0]    bus_out,
  input logic          bus_oe,
  input logic          ready,
  input logic          pg_busy,
  input logic          reading,
  input logic          re_fall,
  input logic [CW-1:0] col
);
  logic [15:0] pg_len;

  always_ff @(posedge clk) begin
    if (!rst_n)       pg_len <= '0;
    else if (pg_busy) pg_len <= pg_len + 1'b1;
    else              pg_len <= '0;
  end

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !bus_oe);  // R8

  AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !ready) |-> (bus_out[6] == 1'b0 && bus_out[7] == prot_n));  // R7

  AST_READ_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && !ready && !pg_busy) |=> ready);  // R9

  AST_PG_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_busy) |-> (pg_len == 16'(PG_CYC)));  // R10

  AST_WP_NO_PG: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_n && !pg_busy) |=> !pg_busy);  // R11

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (re_fall && reading && !sel_n) |=>
      (col == (($past(col) == CW'(PAGE_BYTES - 1)) ? '0 : $past(col) + 1'b1)));  // R3
endmodule

bind nand_bus_frontend nbf_checker #(.PAGE_BYTES(PAGE_BYTES), .PG_CYC(PG_CYC)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .sel_n  (sel_n),
  .prot_n (prot_n),
  .bus_out(bus_out),
  .bus_oe (bus_oe),
  .ready  (ready),
  .pg_busy(pg_busy),
  .reading(reading),
  .re_fall(re_fall),
  .col    (col)
);

// File: tb/nand_bus_frontend_test.sv
`timescale 1ns/1ps
module nand_bus_frontend_test;
  localparam int PB = 264;
  localparam int RDC = 10;
  localparam int PGC = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b0, cmd_latch = 1'b0, addr_latch = 1'b0;
  logic wr_n = 1'b1, rd_n = 1'b1, prot_n = 1'b1;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic bus_oe, ready;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nand_bus_frontend #(.PAGE_BYTES(PB), .RD_CYC(RDC), .PG_CYC(PGC)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cmd_latch(cmd_latch),
    .addr_latch(addr_latch), .wr_n(wr_n), .rd_n(rd_n), .prot_n(prot_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .ready(ready)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---- behavioural reference model ----
  int m_st, m_cnt, m_col, m_acnt;
  bit m_stat, m_prog, m_wep, m_rep;
  int m_rd;
  int m_page[PB];
  int run = 0, last_run = 0;

  always @(posedge clk) begin
    bit wr, rf;
    wr = wr_n && !m_wep;
    rf = !rd_n && m_rep;
    m_wep = wr_n; m_rep = rd_n;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_col = 0; m_acnt = 0; m_stat = 0; m_prog = 0;
      m_rd = 0; m_wep = 1; m_rep = 1;
    end else if (m_st == 5) begin
      if (m_cnt > 1) m_cnt--; else m_st = 0;
      if (!sel_n && wr && cmd_latch && bus_in == 8'h70) m_stat = 1;
    end else if (sel_n) begin
      m_st = 0; m_stat = 0; m_acnt = 0;
    end else if (m_st == 2) begin
      if (m_cnt > 1) m_cnt--; else m_st = 3;
      if (wr && cmd_latch && bus_in == 8'h70) m_stat = 1;
    end else begin
      if (wr && cmd_latch) begin
        if (bus_in == 8'h00) begin m_st = 1; m_prog = 0; m_acnt = 0; m_stat = 0; end
        else if (bus_in == 8'h80 && prot_n) begin m_st = 1; m_prog = 1; m_acnt = 0; m_stat = 0; end
        else if (bus_in == 8'h10 && m_st == 4 && prot_n) begin m_st = 5; m_cnt = PGC; m_stat = 0; end
        else if (bus_in == 8'h70) m_stat = 1;
      end else if (wr && addr_latch && m_st == 1) begin
        if (m_acnt == 0) m_col = bus_in;
        m_acnt++;
        if (m_acnt == 3) begin
          m_acnt = 0;
          if (m_prog) m_st = 4; else begin m_st = 2; m_cnt = RDC; end
        end
      end else if (wr && !addr_latch && m_st == 4 && prot_n) begin
        m_page[m_col] = bus_in;
        m_col = (m_col + 1) % PB;
      end
      if (rf && m_st == 3 && !m_stat) begin
        m_rd = m_page[m_col];
        m_col = (m_col + 1) % PB;
      end
    end
  end

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    bit e_rdy, e_oe;
    #2;
    if (rst_n && !done) begin
      e_rdy = !(m_st == 2 || m_st == 5);
      e_oe  = !sel_n && !rd_n && (m_stat || m_st == 3);
      chk(ready === e_rdy, "R6 model ready", ready, e_rdy);
      chk(bus_oe === e_oe, "R8 model bus_oe", bus_oe, e_oe);
      if (e_oe)
        chk(bus_out === (m_stat ? {prot_n, e_rdy, 6'b0} : 8'(m_rd)),
            "R3 model bus_out", bus_out, m_stat ? {prot_n, e_rdy, 6'b0} : m_rd);
      if (!ready) run++;
      else if (run != 0) begin last_run = run; run = 0; end
    end
  end

  // ---- stimulus helpers ----
  task automatic bwr(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk); cmd_latch = c; addr_latch = a; bus_in = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cmd_latch = 1'b0; addr_latch = 1'b0;
  endtask

  task automatic brd(output logic [7:0] v, output logic oe);
    @(negedge clk); rd_n = 1'b0;
    @(posedge clk); #2; v = bus_out; oe = bus_oe;
    @(negedge clk); rd_n = 1'b1;
  endtask

  task automatic wait_rdy();
    for (int k = 0; k < 100 && !ready; k++) @(negedge clk);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic open_read(input logic [7:0] c);
    bwr(1, 0, 8'h00); bwr(0, 1, c); bwr(0, 1, 8'h12); bwr(0, 1, 8'h03);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic oe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b1, "R8 reset ready", ready, 1);
    chk(bus_oe === 1'b0, "R8 reset bus_oe", bus_oe, 0);

    // R4: load the whole page, R5: commit with a deselect in the middle (R10)
    bwr(1, 0, 8'h80); bwr(0, 1, 8'h00); bwr(0, 1, 8'h00); bwr(0, 1, 8'h00);
    for (int i = 0; i < PB; i++) bwr(0, 0, pat(i));
    bwr(1, 0, 8'h10);
    chk(ready === 1'b0, "R5 busy after commit", ready, 0);
    @(negedge clk); sel_n = 1'b1;
    bwr(1, 0, 8'h00);               // R12 ignored while busy (and deselected)
    @(negedge clk); sel_n = 1'b0;
    bwr(1, 0, 8'h00);               // R12 ignored while busy
    wait_rdy();
    chk(last_run == PGC, "R10 program busy length", last_run, PGC);
    brd(v, oe);
    chk(oe === 1'b0, "R12 no read opened during busy", oe, 0);

    // R2/R6/R3 read from column 5
    open_read(8'd5);
    wait_rdy();
    chk(last_run == RDC, "R6 read busy length", last_run, RDC);
    for (int i = 5; i < 8; i++) begin
      brd(v, oe);
      chk(oe === 1'b1 && v === pat(i), "R3 read byte", v, pat(i));
    end

    // R3 wrap 263 -> 0
    open_read(8'd250);
    wait_rdy();
    for (int i = 250; i < 270; i++) begin
      brd(v, oe);
      chk(v === pat(i % PB), "R3 wrap read", v, pat(i % PB));
    end

    // R7 status, ready and unprotected
    bwr(1, 0, 8'h70);
    brd(v, oe);
    chk(oe === 1'b1 && v === 8'hC0, "R7 status idle", v, 8'hC0);

    // R7/R8 status during read busy
    open_read(8'd0);
    brd(v, oe);
    chk(oe === 1'b0, "R8 no drive during busy", oe, 0);
    bwr(1, 0, 8'h70);
    brd(v, oe);
    chk(oe === 1'b1 && v === 8'h80, "R7 status while busy", v, 8'h80);
    wait_rdy();

    // R9 abort a read busy period
    open_read(8'd1);
    @(negedge clk); sel_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b1, "R9 ready after deselect", ready, 1);
    sel_n = 1'b0;
    brd(v, oe);
    chk(oe === 1'b0, "R9 idle after deselect", oe, 0);

    // R1 write edges ignored while deselected
    @(negedge clk); sel_n = 1'b1;
    bwr(1, 0, 8'h70);
    @(negedge clk); sel_n = 1'b0;
    brd(v, oe);
    chk(oe === 1'b0, "R1 command ignored when deselected", oe, 0);
    bwr(1, 0, 8'h70);
    brd(v, oe);
    chk(oe === 1'b1 && v === 8'hC0, "R1 command taken when selected", v, 8'hC0);

    // R11 write protect
    bwr(1, 0, 8'h80); bwr(0, 1, 8'h00); bwr(0, 1, 8'h00); bwr(0, 1, 8'h00);
    @(negedge clk); prot_n = 1'b0;
    bwr(0, 0, 8'hAA); bwr(0, 0, 8'hAA);
    bwr(1, 0, 8'h10);
    chk(ready === 1'b1, "R11 commit blocked", ready, 1);
    bwr(1, 0, 8'h70);
    brd(v, oe);
    chk(v === 8'h40, "R7 status protected", v, 8'h40);
    bwr(1, 0, 8'h80);
    chk(ready === 1'b1, "R11 load command blocked", ready, 1);
    @(negedge clk); prot_n = 1'b1;
    open_read(8'd0);
    wait_rdy();
    brd(v, oe);
    chk(v === pat(0), "R11 page unchanged col0", v, pat(0));
    brd(v, oe);
    chk(v === pat(1), "R11 page unchanged col1", v, pat(1));

    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule